// File: doc/BRIEF.md
# Reconfigurable Partitioned Lookahead Adder

This block adds two 32-bit words as four 8-bit lanes, two 16-bit lanes or one 32-bit lane. The lane grouping is chosen by a mode input. Inside, each lane is widened by one extra position that sits just above its eight data bits, which gives a 36-bit internal word. That extra position is driven so that it either lets the lane's carry pass upward or kills it. A single carry-lookahead structure therefore splits into independent narrower adders, with no multiplexer on the carry path.

Carries are formed at two levels. Inside each 9-bit segment, per-bit generate and propagate terms are folded into prefix terms. Across segments, the segment group terms form the segment carry-ins in the same way. The packed 32-bit sum and a 4-bit carry-out vector leave through an optional output register.

Top module: `part_lookahead_adder`

## Requirements
- R1: With mode 2'b00, each byte lane k of `sum` equals (byte k of `opA` + byte k of `opB` + carry-in) mod 256, where the carry-in is `cin` for lane 0 and 0 for lanes 1 to 3.
- R2: With mode 2'b01, `sum[15:0]` is (`opA[15:0]` + `opB[15:0]` + `cin`) mod 2^16 and `sum[31:16]` is (`opA[31:16]` + `opB[31:16]`) mod 2^16.
- R3: With mode 2'b10, `sum` is (`opA` + `opB` + `cin`) mod 2^32.
- R4: Mode 2'b11 produces exactly the results of mode 2'b00.
- R5: `cin` enters only the lowest lane. A group whose lowest lane is above lane 0 gets a carry-in of 0, whatever the value of `cin`.
- R6: Bit k of `cout` is the carry out of the group whose top lane is lane k. The top lanes are lane 3 in every mode, lane 1 in mode 2'b01, and every lane in modes 2'b00 and 2'b11. Every other bit of `cout` reads 0.
- R7: A carry out of a group never changes the sum of the group above it.
- R8: With the output register enabled, `sum` and `cout` show the result of the inputs present at the previous rising clock edge. While `rstN` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| opA | input | 32 | First operand, four packed byte lanes |
| opB | input | 32 | Second operand, four packed byte lanes |
| cin | input | 1 | Carry into the lowest lane |
| mode | input | 2 | Lane grouping: 00 four 8-bit lanes, 01 two 16-bit lanes, 10 one 32-bit lane, 11 same as 00 |
| sum | output | 32 | Packed lane sums |
| cout | output | 4 | Carry out per lane, meaningful only at the top lane of each group |

## Verification
A partition bit driven the wrong way shows up as a carry leaking into, or missing from, the lane above. This is seen only when the lower lane actually overflows, so the bench uses all-ones lanes and carry-chain patterns as well as random words. A wrong segment carry-in, or a wrong top-lane mask, shows in the sum or the carry-out vector one clock after the inputs, because the result register is the only storage. Every output is compared on every cycle against a behavioural model, so an error shows up within the same vector that caused it.

// File: rtl/padd_pkg.sv
package padd_pkg;

  // Number of lanes the operand word is split into.
  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    MODE_BYTE  = 2'b00,
    MODE_HALF  = 2'b01,
    MODE_WORD  = 2'b10,
    MODE_ALIAS = 2'b11
  } addMode_e;

  // Strobes from control to datapath.
  // passMask[k]: the partition above lane k lets the carry pass.
  // topMask[k]:  lane k is the top lane of its group and reports its carry out.
  typedef struct packed {
    logic [NUM_LANES-1:0] passMask;
    logic [NUM_LANES-1:0] topMask;
  } laneCtl_t;

endpackage

// File: rtl/padd_control.sv
module padd_control
  import padd_pkg::*;
(
  input  logic [1:0] mode,
  output laneCtl_t   ctl
);

  // Lanes per group for the selected mode; the alias mode falls back to single lanes.
  int unsigned groupLanes;

  always_comb begin
    unique case (addMode_e'(mode))
      MODE_HALF: groupLanes = 2;
      MODE_WORD: groupLanes = NUM_LANES;
      default:   groupLanes = 1;
    endcase
  end

  // A partition passes unless its lane closes a group; the last lane always closes one.
  always_comb begin
    for (int k = 0; k < NUM_LANES; k++) begin
      ctl.passMask[k] = (((k + 1) % groupLanes) != 0) && (k != NUM_LANES - 1);
      ctl.topMask[k]  = ~ctl.passMask[k];
    end
  end

endmodule

// File: rtl/padd_lane_cla.sv
module padd_lane_cla #(
  parameter  int LANE_W = 8,
  localparam int SEG_W  = LANE_W + 1
) (
  input  logic [SEG_W-1:0]  gen,
  input  logic [SEG_W-1:0]  prop,
  input  logic              segCin,
  output logic [LANE_W-1:0] dataSum,
  output logic              groupGen,
  output logic              groupProp,
  output logic              laneCarry
);

  // Prefix terms over bits 0..i of this segment.
  logic [SEG_W-1:0] preGen;
  logic [SEG_W-1:0] preProp;
  logic [SEG_W:0]   carry;

  always_comb begin
    logic gAcc;
    logic pAcc;
    gAcc = 1'b0;
    pAcc = 1'b1;
    for (int i = 0; i < SEG_W; i++) begin
      gAcc       = gen[i] | (prop[i] & gAcc);
      pAcc       = pAcc & prop[i];
      preGen[i]  = gAcc;
      preProp[i] = pAcc;
    end
  end

  // Every carry is formed straight from the prefix terms and the segment carry-in.
  always_comb begin
    carry[0] = segCin;
    for (int i = 0; i < SEG_W; i++) begin
      carry[i+1] = preGen[i] | (preProp[i] & segCin);
    end
  end

  always_comb begin
    for (int i = 0; i < LANE_W; i++) begin
      dataSum[i] = prop[i] ^ carry[i];
    end
  end

  assign groupGen  = preGen[SEG_W-1];
  assign groupProp = preProp[SEG_W-1];
  // The carry into the partition position is the lane's own carry out.
  assign laneCarry = carry[LANE_W];

endmodule

// File: rtl/padd_datapath.sv
module padd_datapath
  import padd_pkg::*;
#(
  parameter  int LANE_W = 8,
  localparam int SEG_W  = LANE_W + 1,
  localparam int W      = LANE_W * NUM_LANES,
  localparam int XW     = SEG_W * NUM_LANES
) (
  input  logic [W-1:0]         opA,
  input  logic [W-1:0]         opB,
  input  logic                 cin,
  input  laneCtl_t             ctl,
  output logic [W-1:0]         sumOut,
  output logic [NUM_LANES-1:0] coutOut
);

  logic [XW-1:0]        extA;
  logic [XW-1:0]        extB;
  logic [XW-1:0]        bitGen;
  logic [XW-1:0]        bitProp;
  logic [NUM_LANES-1:0] segGen;
  logic [NUM_LANES-1:0] segProp;
  logic [NUM_LANES-1:0] segCin;
  logic [NUM_LANES-1:0] laneCarry;

  // Widen the operands: a pass partition is (1,0), a kill partition is (0,0).
  always_comb begin
    for (int k = 0; k < NUM_LANES; k++) begin
      extA[k*SEG_W +: LANE_W]  = opA[k*LANE_W +: LANE_W];
      extB[k*SEG_W +: LANE_W]  = opB[k*LANE_W +: LANE_W];
      extA[k*SEG_W + LANE_W]   = ctl.passMask[k];
      extB[k*SEG_W + LANE_W]   = 1'b0;
    end
  end

  assign bitGen  = extA & extB;
  assign bitProp = extA ^ extB;

  // Second lookahead level across the segments.
  always_comb begin
    logic gAcc;
    logic pAcc;
    gAcc      = 1'b0;
    pAcc      = 1'b1;
    segCin[0] = cin;
    for (int k = 0; k < NUM_LANES - 1; k++) begin
      gAcc        = segGen[k] | (segProp[k] & gAcc);
      pAcc        = pAcc & segProp[k];
      segCin[k+1] = gAcc | (pAcc & cin);
    end
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_seg
    padd_lane_cla #(.LANE_W(LANE_W)) u_lane (
      .gen      (bitGen[k*SEG_W +: SEG_W]),
      .prop     (bitProp[k*SEG_W +: SEG_W]),
      .segCin   (segCin[k]),
      .dataSum  (sumOut[k*LANE_W +: LANE_W]),
      .groupGen (segGen[k]),
      .groupProp(segProp[k]),
      .laneCarry(laneCarry[k])
    );
  end

  assign coutOut = laneCarry & ctl.topMask;

endmodule

// File: rtl/part_lookahead_adder.sv
module part_lookahead_adder
  import padd_pkg::*;
#(
  parameter  int LANE_W       = 8,
  parameter  bit REGISTER_OUT = 1'b1,
  localparam int W            = LANE_W * NUM_LANES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [W-1:0]         opA,
  input  logic [W-1:0]         opB,
  input  logic                 cin,
  input  logic [1:0]           mode,
  output logic [W-1:0]         sum,
  output logic [NUM_LANES-1:0] cout
);

  laneCtl_t             ctl;
  logic [W-1:0]         nxtSum;
  logic [NUM_LANES-1:0] nxtCout;

  padd_control u_ctl (
    .mode(mode),
    .ctl (ctl)
  );

  padd_datapath #(.LANE_W(LANE_W)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .cin    (cin),
    .ctl    (ctl),
    .sumOut (nxtSum),
    .coutOut(nxtCout)
  );

  if (REGISTER_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sum  <= '0;
        cout <= '0;
      end else begin
        sum  <= nxtSum;
        cout <= nxtCout;
      end
    end

    // R8: the outputs follow the datapath by one clock
    assert_out_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (sum == $past(nxtSum)) && (cout == $past(nxtCout)));
  end else begin : g_comb
    assign sum  = nxtSum;
    assign cout = nxtCout;
  end

  // R3: the full-width mode matches a plain add, with the carry on the top lane
  assert_word_add_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10) |-> ({nxtCout[NUM_LANES-1], nxtSum} == ({1'b0, opA} + {1'b0, opB} + (W+1)'(cin))));

  // R1: the lowest byte lane in byte mode
  assert_low_lane_R1: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00) |-> ({nxtCout[0], nxtSum[LANE_W-1:0]} ==
      ({1'b0, opA[LANE_W-1:0]} + {1'b0, opB[LANE_W-1:0]} + (LANE_W+1)'(cin))));

  // R6: a lane that passes its carry upward never reports a carry out
  assert_cout_nontop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (nxtCout & ctl.passMask) == '0);

  // R4: the alias mode blocks every partition
  assert_alias_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11) |-> (ctl.passMask == '0));

  // R5: with a kill partition below lane 1, cin cannot reach lane 1
  assert_cin_isolated_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00) |-> (nxtSum[2*LANE_W-1:LANE_W] == opA[2*LANE_W-1:LANE_W] + opB[2*LANE_W-1:LANE_W]));

endmodule

// File: tb/sim_part_lookahead_adder.sv
module sim_part_lookahead_adder;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] opA;
  logic [31:0] opB;
  logic        cin;
  logic [1:0]  mode;
  logic [31:0] sum;
  logic [3:0]  cout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] expSum[$];
  logic [3:0]  expCout[$];
  string       expTag[$];

  always #2 clk = ~clk;

  part_lookahead_adder u0 (
    .clk (clk),
    .rstN(rstN),
    .opA (opA),
    .opB (opB),
    .cin (cin),
    .mode(mode),
    .sum (sum),
    .cout(cout)
  );

  // Behavioural reference: add each group as a plain integer.
  function automatic void refModel(input logic [31:0] a, input logic [31:0] b,
                                   input logic c, input logic [1:0] m,
                                   output logic [31:0] s, output logic [3:0] co);
    int grp;
    grp = (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
    s  = '0;
    co = '0;
    for (int g0 = 0; g0 < 4; g0 += grp) begin
      longint unsigned mask;
      longint unsigned v;
      int w;
      w    = grp * 8;
      mask = (64'd1 << w) - 1;
      v    = ((longint'(a) >> (g0 * 8)) & mask) + ((longint'(b) >> (g0 * 8)) & mask)
             + ((g0 == 0) ? longint'(c) : 64'd0);
      s    = s | 32'((v & mask) << (g0 * 8));
      co[g0 + grp - 1] = v[w];
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Checks the previous vector, then applies a new one.
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c,
                       input logic [1:0] m, input string tag);
    logic [31:0] s;
    logic [3:0]  co;
    @(negedge clk);
    if (expSum.size() > 0) begin
      string t;
      t = expTag.pop_front();
      check({t, " sum"}, sum, expSum.pop_front());
      check({"R6 cout (", t, ")"}, {28'd0, cout}, {28'd0, expCout.pop_front()});
    end
    opA = a; opB = b; cin = c; mode = m;
    refModel(a, b, c, m, s, co);
    expSum.push_back(s);
    expCout.push_back(co);
    expTag.push_back(tag);
  endtask

  initial begin
    rstN = 1'b0;
    opA = '1; opB = '1; cin = 1'b1; mode = 2'b10;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset sum", sum, 32'd0);
    check("R8 reset cout", {28'd0, cout}, 32'd0);
    rstN = 1'b1;

    // R5: cin reaches lane 0 only; lanes above stay untouched
    apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 2'b00, "R5");
    apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 2'b01, "R5");
    apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 2'b11, "R5");
    // R7: a carry out of a group stops at the partition
    apply(32'h00FF_00FF, 32'h0001_0001, 1'b0, 2'b00, "R7");
    apply(32'h0000_FFFF, 32'h0000_0001, 1'b0, 2'b01, "R7");
    apply(32'h1234_FFFF, 32'h0000_0001, 1'b1, 2'b01, "R7");
    // R3 and R6: a full-width ripple ends in the top lane's carry
    apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 2'b10, "R3");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b10, "R3");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, 2'b10, "R3");
    // R6: every lane overflows in byte mode
    apply(32'h8080_8080, 32'h8080_8080, 1'b0, 2'b00, "R6");

    for (int n = 0; n < 2000; n++) begin
      logic [1:0] m;
      logic [31:0] a;
      logic [31:0] b;
      string tag;
      m = 2'(n % 4);
      a = $urandom();
      b = (n % 7 == 0) ? ~a : $urandom();
      tag = (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : (m == 2'b10) ? "R3" : "R4";
      apply(a, b, 1'($urandom()), m, tag);
    end
    // Flush the last vector.
    apply(32'd0, 32'd0, 1'b0, 2'b00, "R1");
    @(negedge clk);
    check("R8 final sum", sum, 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule